// File: doc/BRIEF.md
# Write-Through Set-Associative Cache Controller

This block is a data cache placed between a processor request port and a slower word-wide main memory. It keeps 8 ways of 64 sets, each line holding 64 bytes. It splits the 32-bit byte address into tag, set and offset fields and compares the tag with all ways of the selected set at once. A read that hits returns its word on the next cycle. A read that misses stalls the processor while the line is fetched one word at a time into the way chosen by an external replacement unit. The requested word is then read out of the freshly filled line.

Writes always go to main memory. A write that hits also updates the cached word, and a write that misses leaves the cache unchanged. A single invalidate input drops every line in one cycle, as an operating system does on a context switch. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `wt_cache`

## Requirements
- R1: The byte address is split as offset addr[5:0] (word select addr[5:2]), set addr[11:6] and tag addr[31:12]. A lookup hits only when a valid way of that set holds the same tag. Equal tags in different sets, or different tags in one set, never alias.
- R2: A read is accepted on a clock edge where req, ready and not we are high. On a hit, rvalid is high in the next cycle with the addressed word on rdata, ready stays high, and mem_req stays low.
- R3: On a read miss, ready is low from the next cycle on. The block issues 16 memory reads (mem_req high, mem_we low) to addresses {addr[31:6], k, 2'b00} for k = 0 to 15 in ascending order, each moving on after a cycle with mem_done high.
- R4: The cycle after the 16th mem_done, rvalid and ready are both still low. In the cycle after that, rvalid pulses with the requested word taken from the filled line, and ready returns high.
- R5: The 3-bit victim input sampled at the edge that accepts a read miss names the way that is refilled. Lines held in the other ways of that set stay valid and keep hitting.
- R6: A write miss performs one memory write of wdata to the full address and allocates no line, so a later read of that address misses.
- R7: A write hit updates the whole cached 32-bit word (addr[1:0] is ignored) and also performs the memory write. A later read hit returns the new data.
- R8: After a write is accepted, mem_req and mem_we are high and ready is low until a cycle with mem_done. Ready is high in the following cycle.
- R9: inv_all clears every valid bit. A request accepted in the same cycle sees an empty cache. A fill that is in progress still completes and leaves its own line valid.
- R10: While reset is asserted, and after it is released, ready is high and mem_req and rvalid are low until a request arrives.
- R11: While mem_req is high and mem_done is low, mem_req, mem_we, mem_addr and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Processor request |
| we | input | 1 | Request is a write |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read completion pulse |
| ready | output | 1 | Controller can accept a request |
| inv_all | input | 1 | Invalidate every line |
| victim | input | 3 | Way to refill on a read miss |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_done |
| mem_done | input | 1 | Memory access completes this cycle |

## Verification
The invalidate input can land in the same cycle as a lookup, or while a line is being filled. Both cases decide whether a later read hits. The bench raises inv_all together with a read of an address known to be cached, where it must see a miss. It also raises inv_all halfway through a fill, after which the filled line must hit and every older line must miss. A behavioural model with its own tag, valid and data tables predicts every output on every clock. Memory latency varies from one access to the next, so the model is also checked against write hits and fill completions that fall on different timings.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_MWR  = 2'd2,
    ST_RESP = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             inv_all,
  input  logic             clr_en,
  input  logic             set_en,
  input  logic [WAY_W-1:0] upd_way,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q, vld_d;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             sel;

    assign sel = (upd_way == WAY_W'(w));

    always_comb begin
      vld_d = vld_q;
      if (inv_all) vld_d = '0;
      if (clr_en && sel) vld_d[lk_set] = 1'b0;
      if (set_en && sel) vld_d[lk_set] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (set_en && sel) tag_q[lk_set] <= lk_tag;
    end

    assign match[w] = vld_q[lk_set] && (tag_q[lk_set] == lk_tag) && !inv_all;
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |match;

  p_one_way_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  p_inv_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !set_en |=> !hit);
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int WORD_W = 32,
  parameter int WPL    = 16,
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  localparam int LINE_W = WORD_W * WPL,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WSEL_W = $clog2(WPL)
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  set_idx,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] way_rd [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w)))
        line_q[set_idx][wr_word*WORD_W +: WORD_W] <= wr_data;
    end

    assign way_rd[w] = line_q[set_idx][rd_word*WORD_W +: WORD_W];
  end

  assign rd_data = way_rd[rd_way];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 6,
  parameter int WAYS   = 8,
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
  localparam int BSEL_W = $clog2(WORD_W / 8),
  localparam int WSEL_W = OFF_W - BSEL_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              ready,
  input  logic [WAY_W-1:0]  victim,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hit_way,
  input  logic [WORD_W-1:0] rd_data,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [SET_W-1:0]  lk_set,
  output logic [WSEL_W-1:0] lk_word,
  output logic              tag_clr,
  output logic              tag_set,
  output logic [WAY_W-1:0]  tag_way,
  output logic              lw_en,
  output logic [WAY_W-1:0]  lw_way,
  output logic [WSEL_W-1:0] lw_word,
  output logic [WORD_W-1:0] lw_data,
  output logic [WAY_W-1:0]  rd_way,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_done
);
  wtc_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [WAY_W-1:0]  vict_q;
  logic [WSEL_W-1:0] cnt_q, cnt_d;
  logic              rvalid_q, rvalid_d;
  logic              addr_en, vict_en, rdata_en;
  logic              idle;

  assign idle = (st_q == ST_IDLE);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    addr_en  = 1'b0;
    vict_en  = 1'b0;
    rdata_en = 1'b0;
    rvalid_d = 1'b0;
    tag_clr  = 1'b0;
    tag_set  = 1'b0;
    lw_en    = 1'b0;
    lw_way   = vict_q;
    lw_word  = cnt_q;
    lw_data  = mem_rdata;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          if (we) begin
            st_d    = ST_MWR;
            addr_en = 1'b1;
            if (hit) begin
              lw_en   = 1'b1;
              lw_way  = hit_way;
              lw_word = addr[OFF_W-1:BSEL_W];
              lw_data = wdata;
            end
          end else if (hit) begin
            rdata_en = 1'b1;
            rvalid_d = 1'b1;
          end else begin
            st_d    = ST_FILL;
            addr_en = 1'b1;
            vict_en = 1'b1;
            cnt_d   = '0;
            tag_clr = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (mem_done) begin
          lw_en = 1'b1;
          if (cnt_q == '1) begin
            tag_set = 1'b1;
            st_d    = ST_RESP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_MWR: begin
        if (mem_done) st_d = ST_IDLE;
      end
      ST_RESP: begin
        rdata_en = 1'b1;
        rvalid_d = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      rvalid_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      vict_q   <= '0;
      rdata_q  <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      rvalid_q <= rvalid_d;
      if (addr_en) begin
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if (vict_en)  vict_q  <= victim;
      if (rdata_en) rdata_q <= rd_data;
    end
  end

  assign lk_tag  = idle ? addr[ADDR_W-1 -: TAG_W] : addr_q[ADDR_W-1 -: TAG_W];
  assign lk_set  = idle ? addr[OFF_W +: SET_W]    : addr_q[OFF_W +: SET_W];
  assign lk_word = idle ? addr[OFF_W-1:BSEL_W]    : addr_q[OFF_W-1:BSEL_W];
  assign tag_way = idle ? victim  : vict_q;
  assign rd_way  = idle ? hit_way : vict_q;

  assign ready     = idle;
  assign rvalid    = rvalid_q;
  assign rdata     = rdata_q;
  assign mem_req   = (st_q == ST_FILL) || (st_q == ST_MWR);
  assign mem_we    = (st_q == ST_MWR);
  assign mem_wdata = wdata_q;
  assign mem_addr  = (st_q == ST_FILL) ?
                     {addr_q[ADDR_W-1:OFF_W], cnt_q, {BSEL_W{1'b0}}} : addr_q;

  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && ready && !we && hit |=> rvalid && ready && !mem_req);

  p_miss_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req && ready && !we && !hit |=> mem_req && !mem_we && !ready &&
                                    (mem_addr[OFF_W-1:0] == '0));

  p_fill_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_done && (mem_addr[OFF_W-1:BSEL_W] == '1)
    |=> !mem_req && !rvalid ##1 rvalid && ready);

  p_write_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req && ready && we |=> mem_req && mem_we &&
                           mem_addr == $past(addr) && mem_wdata == $past(wdata));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_we) &&
                             $stable(mem_addr) && $stable(mem_wdata));
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 64,
  parameter int WAYS       = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
  localparam int WPL    = LINE_BYTES * 8 / WORD_W,
  localparam int WSEL_W = $clog2(WPL),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              ready,
  input  logic              inv_all,
  input  logic [WAY_W-1:0]  victim,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_done
);
  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic [TAG_W-1:0]  lk_tag;
  logic [SET_W-1:0]  lk_set;
  logic [WSEL_W-1:0] lk_word, lw_word;
  logic              hit, tag_clr, tag_set, lw_en;
  logic [WAY_W-1:0]  hit_way, tag_way, lw_way, rd_way;
  logic [WORD_W-1:0] lw_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  wtc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .SET_W(SET_W), .WAYS(WAYS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .ready(ready),
    .victim(victim), .hit(hit), .hit_way(hit_way), .rd_data(rd_data),
    .lk_tag(lk_tag), .lk_set(lk_set), .lk_word(lk_word),
    .tag_clr(tag_clr), .tag_set(tag_set), .tag_way(tag_way),
    .lw_en(lw_en), .lw_way(lw_way), .lw_word(lw_word), .lw_data(lw_data),
    .rd_way(rd_way),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  wtc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_int_n),
    .lk_set(lk_set), .lk_tag(lk_tag), .inv_all(inv_all),
    .clr_en(tag_clr), .set_en(tag_set), .upd_way(tag_way),
    .hit(hit), .hit_way(hit_way)
  );

  wtc_line_store #(
    .WORD_W(WORD_W), .WPL(WPL), .SETS(SETS), .WAYS(WAYS)
  ) u_lines (
    .clk(clk), .set_idx(lk_set),
    .wr_en(lw_en), .wr_way(lw_way), .wr_word(lw_word), .wr_data(lw_data),
    .rd_way(rd_way), .rd_word(lk_word), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_wt_cache.sv
`timescale 1ns/1ps
module sim_wt_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, inv_all = 1'b0, mem_done = 1'b0;
  logic [31:0] addr = '0, wdata = '0, mem_rdata = '0;
  logic [2:0]  victim = '0;
  logic [31:0] rdata, mem_addr, mem_wdata;
  logic        rvalid, ready, mem_req, mem_we;

  wt_cache u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .ready(ready), .inv_all(inv_all),
    .victim(victim), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0, errors = 0, cyc = 0, lat = 0;
  bit    finished = 0;
  string ctx = "R10 reset";

  // behavioural reference model
  int          mst = 0, m_cnt = 0;
  logic [31:0] m_addr, m_wdata, e_rdata = '0, e_maddr = '0;
  logic [2:0]  m_vict;
  logic        e_ready = 1, e_rvalid = 0, e_mreq = 0, e_mwe = 0;
  bit          m_vld [64][8];
  logic [19:0] m_tag [64][8];
  logic [31:0] m_dat [int];
  logic [31:0] mm [int];

  function automatic int key(int s, int w, int wd);
    return (s * 8 + w) * 16 + wd;
  endfunction

  function automatic logic [31:0] mrd(logic [31:0] a);
    if (mm.exists(int'(a >> 2))) return mm[int'(a >> 2)];
    return {a[15:0], ~a[17:2]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; e_rvalid = 0;
      for (int s = 0; s < 64; s++) for (int w = 0; w < 8; w++) m_vld[s][w] = 0;
    end else begin
      int s, hw, ms, mw;
      bit h;
      e_rvalid = 0;
      s = int'(addr[11:6]); h = 0; hw = 0;
      if (mst == 0 && !inv_all)
        for (int w = 0; w < 8; w++)
          if (m_vld[s][w] && m_tag[s][w] == addr[31:12]) begin h = 1; hw = w; end
      if (inv_all)
        for (int a = 0; a < 64; a++) for (int w = 0; w < 8; w++) m_vld[a][w] = 0;
      ms = int'(m_addr[11:6]); mw = int'(m_addr[5:2]);
      case (mst)
        0: if (req) begin
             if (we) begin
               if (h) m_dat[key(s, hw, int'(addr[5:2]))] = wdata;
               m_addr = addr; m_wdata = wdata; mst = 2;
             end else if (h) begin
               e_rdata = m_dat[key(s, hw, int'(addr[5:2]))]; e_rvalid = 1;
             end else begin
               m_addr = addr; m_vict = victim; m_cnt = 0;
               m_vld[s][victim] = 0; mst = 1;
             end
           end
        1: if (mem_done) begin
             m_dat[key(ms, int'(m_vict), m_cnt)] = mem_rdata;
             if (m_cnt == 15) begin
               m_vld[ms][m_vict] = 1; m_tag[ms][m_vict] = m_addr[31:12]; mst = 3;
             end else m_cnt++;
           end
        2: if (mem_done) begin mm[int'(m_addr >> 2)] = m_wdata; mst = 0; end
        default: begin
             e_rdata = m_dat[key(ms, int'(m_vict), mw)]; e_rvalid = 1; mst = 0;
           end
      endcase
    end
    e_ready = (mst == 0);
    e_mreq  = (mst == 1) || (mst == 2);
    e_mwe   = (mst == 2);
    e_maddr = (mst == 1) ? {m_addr[31:6], 4'(m_cnt), 2'b00} : m_addr;
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", ctx, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("ready", 32'(ready), 32'(e_ready));
      cmp("rvalid", 32'(rvalid), 32'(e_rvalid));
      if (e_rvalid) cmp("rdata", rdata, e_rdata);
      cmp("mem_req", 32'(mem_req), 32'(e_mreq));
      if (e_mreq) begin
        cmp("mem_we", 32'(mem_we), 32'(e_mwe));
        cmp("mem_addr", mem_addr, e_maddr);
        if (e_mwe) cmp("mem_wdata", mem_wdata, m_wdata);
      end
    end
  end

  // memory responder with varying latency
  always @(negedge clk) begin
    mem_done = 1'b0;
    if (rst_n && e_mreq) begin
      if (lat == 0) begin
        mem_done  = 1'b1;
        mem_rdata = e_mwe ? 32'hDEAD_BEEF : mrd(e_maddr);
        lat = $urandom_range(0, 3);
      end else lat--;
    end
  end

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic cpu(bit w, logic [31:0] a, logic [31:0] d, logic [2:0] v, bit iv);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; victim = v; inv_all = iv;
    while (!e_ready) @(negedge clk);
    @(negedge clk);
    req = 0; inv_all = 0;
  endtask

  task automatic settle();
    while (!e_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] A = 32'h0001_2340;
  localparam logic [31:0] B = 32'h0005_6340;
  localparam logic [31:0] C = 32'h0001_2380;
  localparam logic [31:0] D = 32'h0009_0000;
  localparam logic [31:0] E = 32'h0007_7700;
  localparam logic [31:0] F = 32'h000A_2340;

  initial begin
    repeat (4) @(negedge clk);
    // R10: outputs idle while in reset
    vectors++;
    if (!(ready === 1'b1 && mem_req === 1'b0 && rvalid === 1'b0)) begin
      errors++;
      $display("FAIL R10 in reset: actual %b%b%b expected 100", ready, mem_req, rvalid);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    ctx = "R3 read miss fill";      cpu(0, A, 0, 3'd3, 0);
    ctx = "R4 fill completion";     settle();
    ctx = "R2 read hit";            cpu(0, A + 4, 0, 3'd0, 0); cpu(0, A + 60, 0, 3'd1, 0); settle();
    ctx = "R5 victim way";          cpu(0, B, 0, 3'd5, 0); settle();
    cpu(0, A + 8, 0, 3'd0, 0); cpu(0, B + 8, 0, 3'd0, 0); settle();
    ctx = "R1 set/tag split";       cpu(0, C, 0, 3'd3, 0); settle(); cpu(0, A, 0, 3'd0, 0); settle();
    ctx = "R7 write hit";           cpu(1, A + 8, 32'h1234_5678, 3'd0, 0); settle();
    cpu(0, A + 8, 0, 3'd0, 0); settle();
    ctx = "R6 write miss";          cpu(1, D + 4, 32'hCAFE_0001, 3'd0, 0); settle();
    cpu(0, D + 4, 0, 3'd2, 0); settle();
    ctx = "R8 write stall";         cpu(1, B, 32'h0BAD_F00D, 3'd0, 0); cpu(1, D, 32'h5555_AAAA, 3'd0, 0); settle();
    ctx = "R9 invalidate";          @(negedge clk); inv_all = 1; @(negedge clk); inv_all = 0;
    cpu(0, A, 0, 3'd1, 0); settle();
    cpu(0, A + 4, 0, 3'd0, 1); settle();       // same-cycle invalidate and lookup
    cpu(0, E, 0, 3'd6, 0);
    repeat (6) @(negedge clk); inv_all = 1; @(negedge clk); inv_all = 0;
    settle(); cpu(0, E + 12, 0, 3'd0, 0); cpu(0, A, 0, 3'd2, 0); settle();
    ctx = "R5 victim way";          cpu(0, F, 0, 3'd2, 0); settle(); cpu(0, A, 0, 3'd4, 0); settle();
    ctx = "R11 request hold";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = {12'h0, 8'(8'h12 + $urandom_range(0, 2)), 6'(13 + $urandom_range(0, 1)),
           4'($urandom_range(0, 15)), 2'b00};
      cpu(($urandom_range(0, 3) == 0), a, $urandom, 3'($urandom_range(0, 7)),
          ($urandom_range(0, 29) == 0));
    end
    settle();
    summary();
  end
endmodule